// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter, four bits wide by default, that a parallel preset can load. It has two count enables and a carry output, so several copies can be joined into one wider counter that still steps on a single clock edge. The first enable, `cnt_en`, goes to every stage at once. The second enable, `carry_in`, comes from the carry output of the stage below. Only `carry_in` takes part in the carry output. The carry therefore travels through one AND gate per stage, and the shared enable does not add to that path.

A build-time parameter chooses how the reset works. With `SYNC_RESET = 0`, an active-low reset clears the count at once and needs no clock edge. With `SYNC_RESET = 1`, the clear takes place on the next rising edge. The carry output is a data-level enable. It is never used as a clock or as a reset. All pins carry plain control or count values, so the block has no valid/ready handshake.

Top module: `presettable_counter`

## Requirements
- R1: When reset is inactive, `load_n` is 1 and both `cnt_en` and `carry_in` are 1, `q` rises by one on the rising edge. It counts in plain binary modulo 2^WIDTH, so the all-ones value is followed by 0.
- R2: With SYNC_RESET=0, a low `rst_n` forces `q` to 0 at once, with no clock edge. It overrides every other input for as long as it stays low.
- R3: With SYNC_RESET=1, a low `rst_n` sampled at a rising edge sets `q` to 0 on that edge, even if a load or a count is requested. Before that edge `q` keeps its value.
- R4: When reset is inactive and `load_n` is 0, `din` is copied into `q` on the rising edge, bit for bit (`din[0]` goes to `q[0]`, the LSB), whatever the state of both enables.
- R5: When reset is inactive, `load_n` is 1 and either `cnt_en` or `carry_in` is 0, `q` keeps its value across the edge.
- R6: `carry_out` is 1 exactly when `q` is all ones and `carry_in` is 1. It follows `carry_in` with no clock edge, and `cnt_en` has no effect on it.
- R7: Two stages, with the lower stage's `carry_out` driving the upper stage's `carry_in` and `cnt_en` shared, count together as one 2*WIDTH-bit counter that runs through its whole range and wraps from its maximum to 0.
- R8: After reset, `q` is 0 and `carry_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asynchronous or synchronous depending on SYNC_RESET |
| load_n | input | 1 | Active-low preset request |
| din | input | WIDTH | Preset value |
| cnt_en | input | 1 | Count enable shared by all stages |
| carry_in | input | 1 | Count enable that also gates `carry_out` |
| q | output | WIDTH | Counter value |
| carry_out | output | 1 | High when `q` is all ones and `carry_in` is high |

## Verification
The hardest case to reach is an 8-bit chain rolling over from 255 to 0. The upper stage may step only on the one cycle in sixteen when the lower stage's carry is high. The bench presets both stages to zero and then drives more than 256 consecutive counts, comparing the joined value with the loop index modulo 256 after every edge. The other hard case is the ordering of the clear against an edge. The bench changes the reset, `carry_in` and `cnt_en` in the middle of a clock period and looks at the outputs both before the next edge and after it.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    M_HOLD  = 2'd0,
    M_COUNT = 2'd1,
    M_LOAD  = 2'd2,
    M_CLEAR = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import cnt_pkg::*;
(
  input  logic      clr_req,
  input  logic      load_n,
  input  logic      cnt_en,
  input  logic      carry_in,
  output cnt_mode_e mode
);
  // precedence: clear, load, count, hold
  always_comb begin
    if (clr_req)                mode = M_CLEAR;
    else if (!load_n)           mode = M_LOAD;
    else if (cnt_en && carry_in) mode = M_COUNT;
    else                        mode = M_HOLD;
  end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_mode_e        mode,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (mode)
      M_CLEAR: nxt = '0;
      M_LOAD:  nxt = din;
      M_COUNT: nxt = cur + ONE;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/cnt_term.sv
module cnt_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             carry_in,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};

  assign carry_out = carry_in && (cur == FULL);
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter bit SYNC_RESET = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             cnt_en,
  input  logic             carry_in,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;
  logic             clr_req;
  cnt_mode_e        mode;

  cnt_mode_dec u_dec (
    .clr_req  (clr_req),
    .load_n   (load_n),
    .cnt_en   (cnt_en),
    .carry_in (carry_in),
    .mode     (mode)
  );

  cnt_next #(.WIDTH(WIDTH)) u_nxt (
    .mode (mode),
    .cur  (q_r),
    .din  (din),
    .nxt  (q_nxt)
  );

  cnt_term #(.WIDTH(WIDTH)) u_term (
    .cur       (q_r),
    .carry_in  (carry_in),
    .carry_out (carry_out)
  );

  generate
    if (SYNC_RESET) begin : g_sync
      assign clr_req = !rst_n;
      always_ff @(posedge clk) q_r <= q_nxt;

      a_r3_sync_clear: assert property (@(posedge clk)
        !rst_n |=> (q == '0));
    end else begin : g_async
      assign clr_req = 1'b0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
      end

      a_r2_async_clear: assert property (@(posedge clk)
        !rst_n |-> (q == '0));
    end
  endgenerate

  assign q = q_r;

  a_r1_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && cnt_en && carry_in) |=> (q == $past(q) + ONE));

  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (q == $past(din)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(cnt_en && carry_in)) |=> $stable(q));

  a_r6_carry_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_in |-> !carry_out);
endmodule

// File: tb/sim_presettable_counter.sv
module sim_presettable_counter;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // async chain: u0 low nibble, u1 high nibble
  logic       rst_a = 1'b0, load_a = 1'b1, en_all = 1'b0, chain_en = 1'b0;
  logic [3:0] din_lo = '0, din_hi = '0, q0, q1;
  logic       c0, c1;

  // sync single stage u2
  logic       rst_s = 1'b0, ld2 = 1'b1, ep2 = 1'b0, et2 = 1'b0;
  logic [3:0] d2 = '0, q2;
  logic       t2;

  presettable_counter #(.WIDTH(4), .SYNC_RESET(1'b0)) u0 (
    .clk(clk), .rst_n(rst_a), .load_n(load_a), .din(din_lo),
    .cnt_en(en_all), .carry_in(chain_en), .q(q0), .carry_out(c0));

  presettable_counter #(.WIDTH(4), .SYNC_RESET(1'b0)) u1 (
    .clk(clk), .rst_n(rst_a), .load_n(load_a), .din(din_hi),
    .cnt_en(en_all), .carry_in(c0), .q(q1), .carry_out(c1));

  presettable_counter #(.WIDTH(4), .SYNC_RESET(1'b1)) u2 (
    .clk(clk), .rst_n(rst_s), .load_n(ld2), .din(d2),
    .cnt_en(ep2), .carry_in(et2), .q(q2), .carry_out(t2));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int exp;
    // R8: reset state
    step();
    chk("R8 q async", int'(q0), 0);
    chk("R8 carry async", int'(c0), 0);
    chk("R8 q sync", int'(q2), 0);
    chk("R8 carry sync", int'(t2), 0);
    rst_a = 1'b1;
    rst_s = 1'b1;

    // R7 / R1: chain preset to 0, then a sweep past the 8-bit wrap
    load_a = 1'b0; din_lo = 4'd0; din_hi = 4'd0;
    step();
    load_a = 1'b1; en_all = 1'b1; chain_en = 1'b1;
    for (int i = 1; i <= 300; i++) begin
      step();
      exp = i % 256;
      chk("R7 chain value", int'({q1, q0}), exp);
      if (exp == 255) chk("R6 upper carry at max", int'(c1), 1);
      if (exp == 0)   chk("R1 wrap to zero", int'(q0), 0);
    end

    // R2: asynchronous clear in mid-period
    rst_a = 1'b0;
    #2;
    chk("R2 clear without edge", int'({q1, q0}), 0);
    step();
    chk("R2 clear overrides count", int'({q1, q0}), 0);
    rst_a = 1'b1;
    step();
    chk("R1 count after release", int'({q1, q0}), 1);
    en_all = 1'b0; chain_en = 1'b0;

    // R4: load every value under every enable combination
    for (int v = 0; v < 16; v++) begin
      for (int c = 0; c < 4; c++) begin
        ld2 = 1'b0; d2 = 4'(v); ep2 = c[0]; et2 = c[1];
        step();
        chk("R4 load", int'(q2), v);
      end
    end

    // R5: hold under the three disabled combinations
    ld2 = 1'b0; d2 = 4'd9;
    step();
    ld2 = 1'b1;
    for (int c = 0; c < 3; c++) begin
      ep2 = c[0]; et2 = c[1];
      step();
      chk("R5 hold", int'(q2), 9);
    end

    // R1 / R6: count to the top, carry gating, wrap
    ld2 = 1'b0; d2 = 4'd13;
    step();
    ld2 = 1'b1; ep2 = 1'b1; et2 = 1'b1;
    step();
    chk("R1 count 14", int'(q2), 14);
    chk("R6 carry low below max", int'(t2), 0);
    step();
    chk("R1 count 15", int'(q2), 15);
    chk("R6 carry at max", int'(t2), 1);
    et2 = 1'b0;
    #1;
    chk("R6 carry follows carry_in low", int'(t2), 0);
    ep2 = 1'b0; et2 = 1'b1;
    #1;
    chk("R6 cnt_en no effect on carry", int'(t2), 1);
    step();
    chk("R5 hold at max", int'(q2), 15);
    ep2 = 1'b1;
    step();
    chk("R1 wrap 15 to 0", int'(q2), 0);

    // R3: synchronous clear beats load and count
    ld2 = 1'b0; d2 = 4'd6;
    step();
    rst_s = 1'b0; d2 = 4'd11;
    #2;
    chk("R3 no clear before edge", int'(q2), 6);
    step();
    chk("R3 clear on edge", int'(q2), 0);
    rst_s = 1'b1; ld2 = 1'b1;
    step();
    chk("R1 count after sync release", int'(q2), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule